// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small controller device between five power modes: run, sleep, stop, standby and shutdown. Software writes a policy word that names a target low-power mode and a sub-option. Writing the policy does not change the mode. The change happens only when the processor signals wait-for-interrupt or wait-for-event. In each mode the sequencer drives one set of registered control outputs: the processor clock gate, the switchable peripheral-domain enable, the retention control, the fast-oscillator and system-oscillator enables, the always-on clock ceiling select, the analog-block permit and the core supply enable.

A wake event returns the device from sleep to run in one step. From stop or standby, the sequencer first turns the oscillators back on. It holds the peripheral domain off and the processor clock gated until the oscillator-ready input confirms the clocks are stable. Retention is then released. Shutdown ignores ordinary wake events. Only a wake-capable pin, a debug attach or the reset pin leaves shutdown, and leaving it clears all state, including the policy word, to its reset value.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset the outputs show run: cpu_clk_en=1, pd_en=1, retain=0, fast_osc_en=1, sys_osc_en=1, aon_div=0, ana_en=1, core_pwr_en=1, mode=0, sub_opt=0.
- R2: A policy write (pol_wr with pol_data, where bits [1:0] select the target mode as 0 sleep, 1 stop, 2 standby, 3 shutdown, and bits [3:2] select the sub-option) updates only sub_opt on the next cycle. The mode does not change.
- R3: In run, wfi with target sleep gives cpu_clk_en=0 and mode=1 on the next cycle, with all other controls as in run. A wake in sleep gives run on the next cycle.
- R4: In run, wfi with target stop gives pd_en=0, retain=1, fast_osc_en=0, sys_osc_en=1, aon_div=1, ana_en=1 and mode=2 on the next cycle.
- R5: In run, wfi with target standby gives pd_en=0, retain=1, fast_osc_en=0, sys_osc_en=0, aon_div=2, ana_en=0 and mode=3 on the next cycle.
- R6: In run, wfi with target shutdown gives core_pwr_en=0 and every clock, oscillator, domain, retention and analog enable low, with aon_div=3 and mode=0. A wake input has no effect in shutdown.
- R7: A wake in stop or standby first gives fast_osc_en=1 and sys_osc_en=1 while pd_en=0, cpu_clk_en=0 and retain=1, with mode, aon_div and ana_en held. The block stays there for at least one cycle and until osc_ready is high. On the cycle after osc_ready is seen there, it returns to run.
- R8: sd_wake in shutdown returns to run on the next cycle and resets the policy to target sleep with sub-option 0.
- R9: sub_opt reports the effective sub-option. Standby accepts 0 to 1, and the other targets accept 0 to 2. Any out-of-range value reads as 0.
- R10: wfi is ignored outside run. wake is ignored in run. sd_wake is ignored outside shutdown. osc_ready is ignored outside the oscillator-restart phase.
- R11: When pol_wr and wfi fall in the same cycle, the entry uses the previously stored policy, and the new policy governs the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_wr | input | 1 | Policy write strobe |
| pol_data | input | 4 | Policy word: [1:0] target, [3:2] sub-option |
| wfi | input | 1 | Wait-for-interrupt/event from the processor |
| wake | input | 1 | Wake event for sleep, stop and standby |
| osc_ready | input | 1 | Oscillators stable after restart |
| sd_wake | input | 1 | Wake pin or debug attach that exits shutdown |
| cpu_clk_en | output | 1 | Processor clock enable |
| pd_en | output | 1 | Switchable peripheral-domain enable |
| retain | output | 1 | Retention control |
| fast_osc_en | output | 1 | Enable for PLL, crystal and external clock input |
| sys_osc_en | output | 1 | System oscillator enable |
| aon_div | output | 2 | Always-on clock ceiling: 0 high, 1 mid tap, 2 slow source, 3 stopped |
| ana_en | output | 1 | Permit for converter, DAC and op-amp |
| core_pwr_en | output | 1 | Core supply enable |
| mode | output | 2 | Current mode: 0 run, 1 sleep, 2 stop, 3 standby |
| sub_opt | output | 2 | Effective policy sub-option |

## Verification
A policy write and a wait-for-interrupt can land in the same cycle. The bench provokes this while standby is stored and sleep is being written. It judges that the entry goes to standby, that sub_opt already shows the new value, and that the following entry goes to sleep. A wake and osc_ready can also arrive together in standby. The bench checks that the restart phase still lasts one cycle before run returns.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int TGT_W  = 2;
  localparam int SUB_W  = 2;
  localparam int MODE_W = 2;
  localparam int DIV_W  = 2;
  localparam int POL_W  = TGT_W + SUB_W;

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_STOP, ST_STBY, ST_WAKE, ST_SHDN
  } lpm_state_e;

  typedef enum logic [TGT_W-1:0] {
    TGT_SLEEP = 2'd0, TGT_STOP = 2'd1, TGT_STBY = 2'd2, TGT_SHDN = 2'd3
  } lpm_tgt_e;

  // Clamp an out-of-range sub-option to zero
  function automatic logic [SUB_W-1:0] eff_sub(lpm_tgt_e t, logic [SUB_W-1:0] s);
    logic [SUB_W-1:0] lim;
    lim = (t == TGT_STBY) ? SUB_W'(1) : SUB_W'(2);
    return (s > lim) ? '0 : s;
  endfunction
endpackage

// File: rtl/lpm_policy_reg.sv
module lpm_policy_reg
  import lpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 wr,
  input  logic [POL_W-1:0]     wdata,
  output lpm_tgt_e             tgt_o,
  output logic [SUB_W-1:0]     sub_o
);
  lpm_tgt_e wt;
  assign wt = lpm_tgt_e'(wdata[TGT_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tgt_o <= TGT_SLEEP;
      sub_o <= '0;
    end else if (wr) begin
      tgt_o <= wt;
      sub_o <= eff_sub(wt, wdata[POL_W-1:TGT_W]);
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wfi,
  input  logic       wake,
  input  logic       osc_ready,
  input  logic       sd_wake,
  input  lpm_tgt_e   tgt,
  output lpm_state_e state_d,
  output logic       sd_exit
);
  lpm_state_e state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: if (wfi) begin
        unique case (tgt)
          TGT_SLEEP: state_d = ST_SLEEP;
          TGT_STOP:  state_d = ST_STOP;
          TGT_STBY:  state_d = ST_STBY;
          TGT_SHDN:  state_d = ST_SHDN;
          default:   state_d = ST_SLEEP;
        endcase
      end
      ST_SLEEP: if (wake) state_d = ST_RUN;
      ST_STOP, ST_STBY: if (wake) state_d = ST_WAKE;
      ST_WAKE: if (osc_ready) state_d = ST_RUN;
      ST_SHDN: if (sd_wake) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  assign sd_exit = (state_q == ST_SHDN) && sd_wake;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/lpm_out_enc.sv
module lpm_out_enc
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  lpm_state_e        state_d,
  output logic              cpu_clk_en,
  output logic              pd_en,
  output logic              retain,
  output logic              fast_osc_en,
  output logic              sys_osc_en,
  output logic [DIV_W-1:0]  aon_div,
  output logic              ana_en,
  output logic              core_pwr_en,
  output logic [MODE_W-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1; pd_en <= 1'b1; retain <= 1'b0;
      fast_osc_en <= 1'b1; sys_osc_en <= 1'b1; aon_div <= DIV_W'(0);
      ana_en <= 1'b1; core_pwr_en <= 1'b1; mode <= MODE_W'(0);
    end else begin
      unique case (state_d)
        ST_RUN, ST_SLEEP: begin
          cpu_clk_en <= (state_d == ST_RUN); pd_en <= 1'b1; retain <= 1'b0;
          fast_osc_en <= 1'b1; sys_osc_en <= 1'b1; aon_div <= DIV_W'(0);
          ana_en <= 1'b1; core_pwr_en <= 1'b1;
          mode <= (state_d == ST_RUN) ? MODE_W'(0) : MODE_W'(1);
        end
        ST_STOP: begin
          cpu_clk_en <= 1'b0; pd_en <= 1'b0; retain <= 1'b1;
          fast_osc_en <= 1'b0; sys_osc_en <= 1'b1; aon_div <= DIV_W'(1);
          ana_en <= 1'b1; core_pwr_en <= 1'b1; mode <= MODE_W'(2);
        end
        ST_STBY: begin
          cpu_clk_en <= 1'b0; pd_en <= 1'b0; retain <= 1'b1;
          fast_osc_en <= 1'b0; sys_osc_en <= 1'b0; aon_div <= DIV_W'(2);
          ana_en <= 1'b0; core_pwr_en <= 1'b1; mode <= MODE_W'(3);
        end
        ST_WAKE: begin
          // oscillators first; domain and cpu wait for ready
          cpu_clk_en <= 1'b0; pd_en <= 1'b0; retain <= 1'b1;
          fast_osc_en <= 1'b1; sys_osc_en <= 1'b1; core_pwr_en <= 1'b1;
        end
        default: begin
          cpu_clk_en <= 1'b0; pd_en <= 1'b0; retain <= 1'b0;
          fast_osc_en <= 1'b0; sys_osc_en <= 1'b0; aon_div <= DIV_W'(3);
          ana_en <= 1'b0; core_pwr_en <= 1'b0; mode <= MODE_W'(0);
        end
      endcase
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pol_wr,
  input  logic [POL_W-1:0]  pol_data,
  input  logic              wfi,
  input  logic              wake,
  input  logic              osc_ready,
  input  logic              sd_wake,
  output logic              cpu_clk_en,
  output logic              pd_en,
  output logic              retain,
  output logic              fast_osc_en,
  output logic              sys_osc_en,
  output logic [DIV_W-1:0]  aon_div,
  output logic              ana_en,
  output logic              core_pwr_en,
  output logic [MODE_W-1:0] mode,
  output logic [SUB_W-1:0]  sub_opt
);
  lpm_tgt_e   tgt;
  lpm_state_e state_d;
  logic       sd_exit;

  lpm_policy_reg u_pol (
    .clk(clk), .rst(rst), .clr(sd_exit), .wr(pol_wr), .wdata(pol_data),
    .tgt_o(tgt), .sub_o(sub_opt)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst(rst), .wfi(wfi), .wake(wake), .osc_ready(osc_ready),
    .sd_wake(sd_wake), .tgt(tgt), .state_d(state_d), .sd_exit(sd_exit)
  );

  lpm_out_enc u_out (
    .clk(clk), .rst(rst), .state_d(state_d),
    .cpu_clk_en(cpu_clk_en), .pd_en(pd_en), .retain(retain),
    .fast_osc_en(fast_osc_en), .sys_osc_en(sys_osc_en), .aon_div(aon_div),
    .ana_en(ana_en), .core_pwr_en(core_pwr_en), .mode(mode)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pol_wr,
  input logic       wfi,
  input logic       wake,
  input logic       osc_ready,
  input logic       cpu_clk_en,
  input logic       pd_en,
  input logic       retain,
  input logic       fast_osc_en,
  input logic       sys_osc_en,
  input logic [1:0] aon_div,
  input logic       ana_en,
  input logic       core_pwr_en
);
  assert_shdn_all_off_R6: assert property (@(posedge clk) disable iff (rst)
    !core_pwr_en |-> (!cpu_clk_en && !fast_osc_en && !sys_osc_en && !pd_en));

  assert_stby_analog_off_R5: assert property (@(posedge clk) disable iff (rst)
    (core_pwr_en && aon_div == 2'd2 && !fast_osc_en) |-> (!ana_en && !sys_osc_en));

  assert_cpu_needs_domain_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (pd_en && !retain));

  assert_release_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(retain) |-> $past(osc_ready));

  assert_write_no_move_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && pol_wr && !wfi) |=> cpu_clk_en);

  assert_sleep_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && pd_en && !wake) |=> (!cpu_clk_en && pd_en));
endmodule

bind lpm_ctrl lpm_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .pol_wr(pol_wr), .wfi(wfi), .wake(wake),
  .osc_ready(osc_ready), .cpu_clk_en(cpu_clk_en), .pd_en(pd_en),
  .retain(retain), .fast_osc_en(fast_osc_en), .sys_osc_en(sys_osc_en),
  .aon_div(aon_div), .ana_en(ana_en), .core_pwr_en(core_pwr_en)
);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, pol_wr = 1'b0, wfi = 1'b0, wake = 1'b0, osc_ready = 1'b0, sd_wake = 1'b0;
  logic [3:0] pol_data = 4'd0;
  logic cpu_clk_en, pd_en, retain, fast_osc_en, sys_osc_en, ana_en, core_pwr_en;
  logic [1:0] aon_div, mode, sub_opt;

  lpm_ctrl dut_i (
    .clk(clk), .rst(rst), .pol_wr(pol_wr), .pol_data(pol_data), .wfi(wfi),
    .wake(wake), .osc_ready(osc_ready), .sd_wake(sd_wake),
    .cpu_clk_en(cpu_clk_en), .pd_en(pd_en), .retain(retain),
    .fast_osc_en(fast_osc_en), .sys_osc_en(sys_osc_en), .aon_div(aon_div),
    .ana_en(ana_en), .core_pwr_en(core_pwr_en), .mode(mode), .sub_opt(sub_opt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [12:0] v(bit c, bit p, bit r, bit h, bit s,
                                    logic [1:0] d, bit a, bit k, logic [1:0] m, logic [1:0] u);
    return {c, p, r, h, s, d, a, k, m, u};
  endfunction
  function automatic logic [12:0] e_run(logic [1:0] u);   return v(1,1,0,1,1,2'd0,1,1,2'd0,u); endfunction
  function automatic logic [12:0] e_slp(logic [1:0] u);   return v(0,1,0,1,1,2'd0,1,1,2'd1,u); endfunction
  function automatic logic [12:0] e_stp(logic [1:0] u);   return v(0,0,1,0,1,2'd1,1,1,2'd2,u); endfunction
  function automatic logic [12:0] e_stb(logic [1:0] u);   return v(0,0,1,0,0,2'd2,0,1,2'd3,u); endfunction
  function automatic logic [12:0] e_sd(logic [1:0] u);    return v(0,0,0,0,0,2'd3,0,0,2'd0,u); endfunction
  function automatic logic [12:0] e_wstp(logic [1:0] u);  return v(0,0,1,1,1,2'd1,1,1,2'd2,u); endfunction
  function automatic logic [12:0] e_wstb(logic [1:0] u);  return v(0,0,1,1,1,2'd2,0,1,2'd3,u); endfunction

  // driver: one cycle of stimulus plus the expected outputs after the edge
  task automatic cyc(bit r, bit pw, logic [3:0] pd, bit wf, bit wk, bit rdy, bit sdw,
                     logic [12:0] e, string tag);
    @(negedge clk);
    rst = r; pol_wr = pw; pol_data = pd; wfi = wf; wake = wk; osc_ready = rdy; sd_wake = sdw;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares one item per edge, 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [12:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {cpu_clk_en, pd_en, retain, fast_osc_en, sys_osc_en, aon_div, ana_en,
             core_pwr_en, mode, sub_opt};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(1,0,4'h0,0,0,0,0, e_run(0), "R1 reset");
    cyc(1,0,4'h0,0,0,0,0, e_run(0), "R1 reset hold");
    cyc(0,0,4'h0,0,0,0,0, e_run(0), "R1 after release");
    cyc(0,1,4'b0100,0,0,0,0, e_run(1), "R2 write sleep sub1 no move, R9");
    cyc(0,0,4'h0,0,0,0,0, e_run(1), "R2 idle stays run");
    cyc(0,0,4'h0,0,1,0,0, e_run(1), "R10 wake ignored in run");
    cyc(0,0,4'h0,0,0,0,1, e_run(1), "R10 sd_wake ignored in run");
    cyc(0,0,4'h0,1,0,0,0, e_slp(1), "R3 enter sleep");
    cyc(0,0,4'h0,1,0,1,0, e_slp(1), "R10 wfi and osc_ready ignored in sleep");
    cyc(0,0,4'h0,0,1,0,0, e_run(1), "R3 wake from sleep");
    cyc(0,1,4'b1101,0,0,0,0, e_run(0), "R9 stop sub3 reads 0");
    cyc(0,0,4'h0,1,0,0,0, e_stp(0), "R4 enter stop");
    cyc(0,0,4'h0,0,0,1,0, e_stp(0), "R10 osc_ready ignored in stop");
    cyc(0,0,4'h0,0,1,0,0, e_wstp(0), "R7 restart from stop");
    cyc(0,0,4'h0,0,0,0,0, e_wstp(0), "R7 waits for ready");
    cyc(0,0,4'h0,0,0,1,0, e_run(0), "R7 run after ready");
    cyc(0,1,4'b1010,0,0,0,0, e_run(0), "R9 standby sub2 reads 0");
    cyc(0,1,4'b0110,0,0,0,0, e_run(1), "R9 standby sub1");
    cyc(0,0,4'h0,1,0,0,0, e_stb(1), "R5 enter standby");
    cyc(0,0,4'h0,0,1,1,0, e_wstb(1), "R7 restart from standby with early ready");
    cyc(0,0,4'h0,0,0,1,0, e_run(1), "R7 run after standby");
    cyc(0,1,4'b1000,1,0,0,0, e_stb(2), "R11 entry uses old policy");
    cyc(0,0,4'h0,0,1,0,0, e_wstb(2), "R11 restart");
    cyc(0,0,4'h0,0,0,1,0, e_run(2), "R11 back in run");
    cyc(0,0,4'h0,1,0,0,0, e_slp(2), "R11 new policy governs next entry");
    cyc(0,0,4'h0,0,1,0,0, e_run(2), "R3 wake");
    cyc(0,1,4'b1011,0,0,0,0, e_run(2), "R9 shutdown sub2");
    cyc(0,0,4'h0,1,0,0,0, e_sd(2), "R6 enter shutdown");
    cyc(0,0,4'h0,0,1,1,0, e_sd(2), "R6 wake ignored in shutdown");
    cyc(0,0,4'h0,1,0,0,0, e_sd(2), "R10 wfi ignored in shutdown");
    cyc(0,0,4'h0,0,0,0,1, e_run(0), "R8 exit shutdown clears policy");
    cyc(0,0,4'h0,1,0,0,0, e_slp(0), "R8 default target is sleep");
    cyc(0,0,4'h0,0,1,0,0, e_run(0), "R3 wake after R8");
    cyc(0,0,4'h0,0,0,0,0, e_run(0), "R1 idle tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule